// File: doc/BRIEF.md
# CAN Receive Frame-Tail Checker

This block handles the last bits of a classical CAN frame: the CRC sequence, the CRC delimiter, the single-bit ACK slot and the ACK delimiter. Surrounding logic supplies one de-stuffed bit per bit time. A one-clock `samplePt` strobe marks the bit's sample point. A level strobe names the field the bit belongs to. The CRC that the node computed itself arrives as a word. The block collects the received CRC and compares it with the computed one. It decides whether the node acknowledges the frame. It reports form errors and acknowledgement errors. It also decides in which bit an error frame must begin.

A CRC mismatch is not reported at once. A receiver holding a bad CRC keeps its transmit line recessive through the ACK slot. It requests the error frame only when the ACK delimiter has been sampled, so the error frame starts on the bit that follows. Every detected error is recorded in a capture register as a 3-bit type code and a 3-bit position code. The capture keeps the first error of each frame. Other frame logic can report its own errors into the same register through a side port.

Top module: `canTailChecker`

## Requirements
- R1: At each sample point in the CRC field, the received bit is shifted in, most significant bit first. At the first sample point of the CRC delimiter, the collected value is compared with `crcCalc` over bit positions below `crcWidth`. `crcWidth` is 15 for classical CAN. Bits at or above `crcWidth` never affect the result.
- R2: A receiver (`isTransmitter`=0) whose CRC matched drives `txLine` dominant (0) while `inAckSlot` is high. In every other case `txLine` is recessive (1).
- R3: A receiver with a CRC mismatch keeps `txLine` recessive during the whole ACK slot, including its sample point, even when `rxBit` is dominant there.
- R4: A CRC mismatch raises `errFrameReq` for exactly one clock, in the cycle after the ACK-delimiter sample point. `errFrameReq` stays low before that point. Every request is a one-clock pulse in the cycle after a sample point.
- R5: A CRC mismatch is captured as type CRC (4) with position ACK (5). Position 5 stands for the CRC delimiter, the ACK slot and the ACK delimiter together.
- R6: After reset the capture reads type 0 and position "other" (0). `txLine` is 1 and `errFrameReq` is 0.
- R7: A dominant bit sampled in the CRC delimiter is captured as a form error (type 2, position 5), and a request follows that sample point. A CRC mismatch in the same frame is then discarded: no second request is made, and the capture stays form.
- R8: A dominant bit sampled in the ACK delimiter is captured as a form error (type 2, position 5) with a request.
- R9: A transmitter (`isTransmitter`=1) does not check the CRC and never drives `txLine` dominant. A dominant ACK sample causes no request. A recessive ACK sample is captured as an ACK error (type 3, position 5), and a request follows it.
- R10: Only the first error after `frameStart` is captured and requested. The capture holds its value across later frames until the next error is detected.
- R11: The comparison result is latched at the CRC-delimiter sample point. A later change of `crcCalc` has no effect on the ACK or the request.
- R12: An `extErr` pulse records `extErrType`/`extErrPos` if it is the first error of the frame, and it raises no request. If an internal error is detected in the same clock, the internal error is captured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| frameStart | input | 1 | One-clock pulse at start of frame; re-arms the checker |
| samplePt | input | 1 | One-clock sample-point strobe of the current bit |
| rxBit | input | 1 | De-stuffed received bit, 0 = dominant |
| inCrcField | input | 1 | Current bit belongs to the CRC sequence |
| inCrcDelim | input | 1 | Current bit is the CRC delimiter |
| inAckSlot | input | 1 | Current bit is the ACK slot |
| inAckDelim | input | 1 | Current bit is the ACK delimiter |
| isTransmitter | input | 1 | Node is the frame's transmitter |
| crcWidth | input | 5 | Number of valid CRC bits (15) |
| crcCalc | input | 21 | Locally computed CRC, right aligned |
| extErr | input | 1 | Error reported by other frame logic |
| extErrType | input | 3 | Type code of the reported error |
| extErrPos | input | 3 | Position code of the reported error |
| txLine | output | 1 | Transmit contribution, 0 = dominant |
| errFrameReq | output | 1 | One-clock request to start an error frame |
| capErrType | output | 3 | Captured error type |
| capErrPos | output | 3 | Captured error position |

## Verification
A wrong latched comparison shows up first at `txLine` during the ACK slot, within the same bit. A wrong pending-mismatch flag shows up one bit later as a missing request, or a premature one, around the ACK delimiter. A stale first-error flag shows at the capture outputs and at `errFrameReq` in the cycle after the offending sample point. A missed re-arm shows only when the next frame produces its first error, so the scenarios chain frames back to back.

// File: rtl/canTailPkg.sv
package canTailPkg;

  typedef enum logic [2:0] {
    ERR_BIT   = 3'd0,
    ERR_STUFF = 3'd1,
    ERR_FORM  = 3'd2,
    ERR_ACK   = 3'd3,
    ERR_CRC   = 3'd4
  } errTypeE;

  typedef enum logic [2:0] {
    POS_OTHER = 3'd0,
    POS_ARB   = 3'd1,
    POS_CTRL  = 3'd2,
    POS_DATA  = 3'd3,
    POS_CRC   = 3'd4,
    POS_ACK   = 3'd5
  } errPosE;

  // strobes from control to datapath
  typedef struct packed {
    logic    clrCrc;
    logic    shiftCrc;
    logic    capEn;
    errTypeE capType;
    errPosE  capPos;
  } tailStrobeT;

endpackage

// File: rtl/canTailData.sv
module canTailData
  import canTailPkg::*;
#(
  parameter int MAX_CRC_W = 21,
  localparam int WW = $clog2(MAX_CRC_W + 1)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  tailStrobeT           strb,
  input  logic                 rxBit,
  input  logic [WW-1:0]        crcWidth,
  input  logic [MAX_CRC_W-1:0] crcCalc,
  output logic                 crcMismatch,
  output logic [2:0]           capErrType,
  output logic [2:0]           capErrPos
);

  logic [MAX_CRC_W-1:0] rxCrc;
  logic [MAX_CRC_W-1:0] widthMask;

  // valid-bit mask derived from the selected CRC width
  for (genvar i = 0; i < MAX_CRC_W; i++) begin : g_mask
    assign widthMask[i] = (crcWidth > WW'(i));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxCrc <= '0;
    end else if (strb.clrCrc) begin
      rxCrc <= '0;
    end else if (strb.shiftCrc) begin
      rxCrc <= {rxCrc[MAX_CRC_W-2:0], rxBit};
    end
  end

  assign crcMismatch = |((rxCrc ^ crcCalc) & widthMask);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      capErrType <= ERR_BIT;
      capErrPos  <= POS_OTHER;
    end else if (strb.capEn) begin
      capErrType <= strb.capType;
      capErrPos  <= strb.capPos;
    end
  end

  // R10: capture changes only on a capture strobe
  p_cap_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    !strb.capEn |=> $stable({capErrType, capErrPos}));

  // R1: received CRC frozen when not shifting or clearing
  p_crc_frozen_r1: assert property (@(posedge clk) disable iff (!rstN)
    !strb.shiftCrc && !strb.clrCrc |=> $stable(rxCrc));

endmodule

// File: rtl/canTailCtrl.sv
module canTailCtrl
  import canTailPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       frameStart,
  input  logic       samplePt,
  input  logic       rxBit,
  input  logic       inCrcField,
  input  logic       inCrcDelim,
  input  logic       inAckSlot,
  input  logic       inAckDelim,
  input  logic       isTransmitter,
  input  logic       extErr,
  input  logic [2:0] extErrType,
  input  logic [2:0] extErrPos,
  input  logic       crcMismatch,
  output tailStrobeT strb,
  output logic       txLine,
  output logic       errFrameReq
);

  logic crcDone;
  logic crcBad;
  logic errSeen;

  logic sampCrc, sampDelim, sampAck, sampAckDel;
  logic formErr, ackErr, crcFire, intErr;
  errTypeE intType;

  assign sampCrc    = samplePt & inCrcField;
  assign sampDelim  = samplePt & inCrcDelim;
  assign sampAck    = samplePt & inAckSlot;
  assign sampAckDel = samplePt & inAckDelim;

  // fixed-form bits sampled dominant
  assign formErr = (sampDelim | sampAckDel) & ~rxBit & ~errSeen;
  // transmitter saw nobody acknowledge
  assign ackErr  = sampAck & isTransmitter & rxBit & ~errSeen;
  // pending mismatch released at the end of the ACK delimiter
  assign crcFire = sampAckDel & rxBit & crcBad & ~errSeen;
  assign intErr  = formErr | ackErr | crcFire;

  always_comb begin
    if (formErr)     intType = ERR_FORM;
    else if (ackErr) intType = ERR_ACK;
    else             intType = ERR_CRC;
  end

  always_comb begin
    strb.clrCrc   = frameStart;
    strb.shiftCrc = sampCrc & ~crcDone;
    strb.capEn    = (intErr | extErr) & ~errSeen;
    if (intErr) begin
      strb.capType = intType;
      strb.capPos  = POS_ACK;
    end else begin
      strb.capType = errTypeE'(extErrType);
      strb.capPos  = errPosE'(extErrPos);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      crcDone     <= 1'b0;
      crcBad      <= 1'b0;
      errSeen     <= 1'b0;
      errFrameReq <= 1'b0;
    end else begin
      errFrameReq <= intErr;
      if (frameStart) begin
        crcDone <= 1'b0;
        crcBad  <= 1'b0;
        errSeen <= 1'b0;
      end else begin
        if (strb.capEn) errSeen <= 1'b1;
        if (sampDelim && !crcDone) begin
          crcDone <= 1'b1;
          // a dominant delimiter is a form error; the mismatch is dropped
          crcBad  <= crcMismatch & rxBit & ~isTransmitter;
        end
      end
    end
  end

  assign txLine = ~(inAckSlot & ~isTransmitter & crcDone & ~crcBad & ~errSeen);

  // R4: request is a single-clock pulse
  p_req_pulse_r4: assert property (@(posedge clk) disable iff (!rstN)
    errFrameReq |=> !errFrameReq);

  // R4: request only follows a sample point
  p_req_after_sample_r4: assert property (@(posedge clk) disable iff (!rstN)
    errFrameReq |-> $past(samplePt));

  // R3: pending mismatch never acknowledges
  p_ack_withheld_r3: assert property (@(posedge clk) disable iff (!rstN)
    crcBad && inAckSlot |-> txLine);

  // R9: transmitter never drives dominant here
  p_tx_no_ack_r9: assert property (@(posedge clk) disable iff (!rstN)
    isTransmitter |-> txLine);

endmodule

// File: rtl/canTailChecker.sv
module canTailChecker
  import canTailPkg::*;
#(
  parameter int MAX_CRC_W = 21,
  localparam int WW = $clog2(MAX_CRC_W + 1)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 frameStart,
  input  logic                 samplePt,
  input  logic                 rxBit,
  input  logic                 inCrcField,
  input  logic                 inCrcDelim,
  input  logic                 inAckSlot,
  input  logic                 inAckDelim,
  input  logic                 isTransmitter,
  input  logic [WW-1:0]        crcWidth,
  input  logic [MAX_CRC_W-1:0] crcCalc,
  input  logic                 extErr,
  input  logic [2:0]           extErrType,
  input  logic [2:0]           extErrPos,
  output logic                 txLine,
  output logic                 errFrameReq,
  output logic [2:0]           capErrType,
  output logic [2:0]           capErrPos
);

  tailStrobeT strb;
  logic       crcMismatch;

  canTailCtrl u_ctrl (
    .clk(clk), .rstN(rstN), .frameStart(frameStart), .samplePt(samplePt),
    .rxBit(rxBit), .inCrcField(inCrcField), .inCrcDelim(inCrcDelim),
    .inAckSlot(inAckSlot), .inAckDelim(inAckDelim),
    .isTransmitter(isTransmitter), .extErr(extErr), .extErrType(extErrType),
    .extErrPos(extErrPos), .crcMismatch(crcMismatch), .strb(strb),
    .txLine(txLine), .errFrameReq(errFrameReq)
  );

  canTailData #(.MAX_CRC_W(MAX_CRC_W)) u_data (
    .clk(clk), .rstN(rstN), .strb(strb), .rxBit(rxBit), .crcWidth(crcWidth),
    .crcCalc(crcCalc), .crcMismatch(crcMismatch), .capErrType(capErrType),
    .capErrPos(capErrPos)
  );

  // R6: capture is "other" when reset is released
  p_reset_pos_r6: assert property (@(posedge clk)
    $rose(rstN) |-> (capErrPos == 3'd0 && capErrType == 3'd0));

endmodule

// File: tb/test_canTailChecker.sv
module test_canTailChecker;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        frameStart = 1'b0;
  logic        samplePt = 1'b0;
  logic        rxBit = 1'b1;
  logic        inCrcField = 1'b0, inCrcDelim = 1'b0, inAckSlot = 1'b0, inAckDelim = 1'b0;
  logic        isTransmitter = 1'b0;
  logic [4:0]  crcWidth = 5'd15;
  logic [20:0] crcCalc = '0;
  logic        extErr = 1'b0;
  logic [2:0]  extErrType = '0, extErrPos = '0;
  logic        txLine, errFrameReq;
  logic [2:0]  capErrType, capErrPos;

  int checks = 0, fails = 0, reqCnt = 0;
  bit finished = 0;
  logic txAck;
  int rDelim, rAck, rAckDel, rEnd, r0;

  always #5 clk = ~clk;

  canTailChecker i_canTailChecker (
    .clk(clk), .rstN(rstN), .frameStart(frameStart), .samplePt(samplePt),
    .rxBit(rxBit), .inCrcField(inCrcField), .inCrcDelim(inCrcDelim),
    .inAckSlot(inAckSlot), .inAckDelim(inAckDelim), .isTransmitter(isTransmitter),
    .crcWidth(crcWidth), .crcCalc(crcCalc), .extErr(extErr),
    .extErrType(extErrType), .extErrPos(extErrPos), .txLine(txLine),
    .errFrameReq(errFrameReq), .capErrType(capErrType), .capErrPos(capErrPos)
  );

  always @(negedge clk) if (rstN && errFrameReq) reqCnt++;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic checkEq(input string tag, input int act, input int exp);
    check(act == exp, tag, act, exp);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  // fld: 0 none, 1 crc, 2 crc delimiter, 3 ack slot, 4 ack delimiter
  task automatic doBit(input int fld, input logic b, input bit ext = 0);
    @(negedge clk);
    inCrcField = (fld == 1); inCrcDelim = (fld == 2);
    inAckSlot  = (fld == 3); inAckDelim = (fld == 4);
    rxBit = b;
    @(negedge clk);
    if (fld == 3) txAck = txLine;
    samplePt = 1'b1;
    extErr = ext;
    @(negedge clk);
    samplePt = 1'b0;
    extErr = 1'b0;
    @(negedge clk);
  endtask

  task automatic startFrame();
    @(negedge clk);
    frameStart = 1'b1;
    @(negedge clk);
    frameStart = 1'b0;
  endtask

  task automatic runTail(input logic [14:0] rx, input logic [20:0] calcEarly,
                         input logic [20:0] calcLate, input bit tx,
                         input logic dl, input logic ak, input logic ad);
    startFrame();
    isTransmitter = tx;
    crcCalc = calcEarly;
    r0 = reqCnt;
    for (int i = 14; i >= 0; i--) doBit(1, rx[i]);
    doBit(2, dl);
    rDelim = reqCnt - r0;
    crcCalc = calcLate;
    doBit(3, ak);
    rAck = reqCnt - r0;
    doBit(4, ad);
    rAckDel = reqCnt - r0;
    doBit(0, 1'b1);
    rEnd = reqCnt - r0;
    isTransmitter = 1'b0;
  endtask

  task automatic t_reset();
    checkEq("R6 type", capErrType, 0);
    checkEq("R6 pos", capErrPos, 0);
    checkEq("R6 txLine", txLine, 1);
    checkEq("R6 req", errFrameReq, 0);
  endtask

  task automatic t_goodRx();
    // upper bits of calc differ: R1 says they are ignored
    runTail(15'h4A5B, {6'h2A, 15'h4A5B}, {6'h2A, 15'h4A5B}, 0, 1, 0, 1);
    checkEq("R2 ack dominant", txAck, 0);
    checkEq("R1 upper bits ignored, no req", rEnd, 0);
    checkEq("R2 txLine idle", txLine, 1);
    checkEq("R6 capture untouched type", capErrType, 0);
    // narrower width: mismatch only at bit 10 is outside 8 bits
    crcWidth = 5'd8;
    runTail(15'h1234, 21'h1234 ^ 21'h400, 21'h1234 ^ 21'h400, 0, 1, 0, 1);
    checkEq("R1 width 8 ignores bit 10", txAck, 0);
    crcWidth = 5'd15;
  endtask

  task automatic t_crcBad();
    runTail(15'h0F0F, 21'h0F0E, 21'h0F0E, 0, 1, 0, 1);
    checkEq("R3 ack withheld at sample", txAck, 1);
    checkEq("R4 no req before ack delim end", rAck, 0);
    checkEq("R4 one req after ack delim", rAckDel, 1);
    checkEq("R4 single pulse", rEnd, 1);
    checkEq("R5 type crc", capErrType, 4);
    checkEq("R5 pos ack", capErrPos, 5);
  endtask

  task automatic t_latch();
    runTail(15'h3333, 21'h3333, 21'h0001, 0, 1, 0, 1);
    checkEq("R11 late calc change keeps ack", txAck, 0);
    checkEq("R11 late calc change no req", rEnd, 0);
    runTail(15'h3333, 21'h3330, 21'h3333, 0, 1, 0, 1);
    checkEq("R11 late match keeps mismatch", rAckDel, 1);
    checkEq("R11 late match ack withheld", txAck, 1);
  endtask

  task automatic t_formDelim();
    runTail(15'h5555, 21'h5554, 21'h5554, 0, 0, 0, 1);
    checkEq("R7 req after delim", rDelim, 1);
    checkEq("R7 no second req", rEnd, 1);
    checkEq("R7 type form", capErrType, 2);
    checkEq("R7 pos ack", capErrPos, 5);
  endtask

  task automatic t_formAckDel();
    runTail(15'h7001, 21'h7001, 21'h7001, 0, 1, 0, 0);
    checkEq("R8 no req before ack delim", rAck, 0);
    checkEq("R8 req after ack delim", rAckDel, 1);
    checkEq("R8 type form", capErrType, 2);
  endtask

  task automatic t_transmitter();
    runTail(15'h1111, 21'h2222, 21'h2222, 1, 1, 0, 1);
    checkEq("R9 tx never acks", txAck, 1);
    checkEq("R9 dominant ack no req", rEnd, 0);
    checkEq("R9 capture kept from before", capErrType, 2);
    runTail(15'h1111, 21'h1111, 21'h1111, 1, 1, 1, 1);
    checkEq("R9 req after recessive ack", rAck, 1);
    checkEq("R9 type ack", capErrType, 3);
    checkEq("R9 pos ack", capErrPos, 5);
  endtask

  task automatic t_firstOnly();
    // ack error first, then dominant ack delimiter in same frame
    runTail(15'h0AAA, 21'h0AAA, 21'h0AAA, 1, 1, 1, 0);
    checkEq("R10 only first error requested", rEnd, 1);
    checkEq("R10 first error kept", capErrType, 3);
    runTail(15'h0AAA, 21'h0AAA, 21'h0AAA, 0, 1, 0, 1);
    checkEq("R10 holds across clean frame", capErrType, 3);
    runTail(15'h0AAA, 21'h0AAA, 21'h0AAA, 0, 1, 0, 0);
    checkEq("R10 rearmed by frameStart", capErrType, 2);
  endtask

  task automatic t_external();
    startFrame();
    r0 = reqCnt;
    extErrType = 3'd1; extErrPos = 3'd2;
    doBit(0, 1'b1, 1);
    checkEq("R12 ext type", capErrType, 1);
    checkEq("R12 ext pos", capErrPos, 2);
    checkEq("R12 ext no req", reqCnt - r0, 0);
    // same clock as a form error: internal wins
    startFrame();
    extErrType = 3'd0; extErrPos = 3'd3;
    for (int i = 14; i >= 0; i--) doBit(1, 1'b0);
    crcCalc = '0;
    doBit(2, 1'b0, 1);
    checkEq("R12 internal wins type", capErrType, 2);
    checkEq("R12 internal wins pos", capErrPos, 5);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_goodRx();
    t_crcBad();
    t_latch();
    t_formDelim();
    t_formAckDel();
    t_transmitter();
    t_firstOnly();
    t_external();
    repeat (3) @(negedge clk);
    summary();
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      summary();
    end
  end

endmodule